// File: doc/BRIEF.md
# Percussion Mode Phase Synthesizer

This block supplies the percussion path of a three-channel group in a two-operator FM tone generator. It holds the drum key sources that a rhythm key write sets. It merges them with the operators' normal key sources and flags the cycle in which an operator goes from silent to keyed. It also builds the replacement phase indices that three percussion operators use in place of their own phase accumulators.

The replacement phases are combinational. They are formed from two reference operator phases (the first reference belongs to channel 7 operator 0, the second to channel 8 operator 1) and one noise bit. The envelope generator, the waveform lookup and the noise source sit outside the block. When rhythm mode is off, the drum key sources clear and no phase is overridden.

Top module: `rhy_perc_phase`

## Requirements
- R1: The five key bits map to operators by position: bit 0 hi-hat (ch7 op0), bit 1 top cymbal (ch8 op1), bit 2 tom (ch8 op0), bit 3 snare (ch7 op1), bit 4 bass drum (ch6 op0). `drum_key_o` uses the same bit order. A write strobe while rhythm mode is on loads `key_bits_i` into `drum_key_o` at the next clock edge.
- R2: If no write strobe is given, `drum_key_o` keeps its value while rhythm mode stays on, whatever `key_bits_i` does.
- R3: While `rhy_en_i` is low, `drum_key_o` clears at the next edge and write strobes are ignored. In the same state `ovr_mask_o` is 0 and all three phase outputs are 0.
- R4: `op_on_o[i]` is the OR of `norm_key_i[i]` and `drum_key_o[i]`. A drum write changes only the drum source.
- R5: `op_start_o[i]` is 1 only while `op_on_o[i]` is 1 and was 0 at the previous clock edge. An operator that is already on through one source gives no start when the other source is set.
- R6: Define c = A[3] | (A[7]^A[2]) | (B[5]^B[3]), with A the first reference phase and B the second. In rhythm mode the hi-hat phase is (c<<9) | (0x34 << 2*(c^noise)).
- R7: In rhythm mode the snare phase is (0x100 << A[8]) ^ (noise << 8).
- R8: In rhythm mode the top-cymbal phase is 0x100 | (c<<9).
- R9: In rhythm mode `ovr_mask_o` is 5'b01011: hi-hat, top cymbal and snare are overridden. Tom and bass drum are not.
- R10: After reset, `drum_key_o` is 0 and the previous-key state is 0, so a normal key present at the first edge after reset gives a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rhy_en_i | input | 1 | Rhythm mode enable |
| key_wr_i | input | 1 | Rhythm key write strobe |
| key_bits_i | input | 5 | Rhythm key bits (order as R1) |
| norm_key_i | input | 5 | Normal key source per percussion operator |
| ref_a_phase_i | input | 10 | Phase index of ch7 op0 |
| ref_b_phase_i | input | 10 | Phase index of ch8 op1 |
| noise_i | input | 1 | Noise bit |
| drum_key_o | output | 5 | Registered drum key sources |
| op_on_o | output | 5 | Operator keyed (either source) |
| op_start_o | output | 5 | Off-to-on transition flag |
| ovr_mask_o | output | 5 | Operators taking a substitute phase |
| hh_phase_o | output | 10 | Hi-hat phase |
| sd_phase_o | output | 10 | Snare phase |
| tc_phase_o | output | 10 | Top-cymbal phase |

## Verification
The phase outputs are swept over every value of the first reference phase. Each sweep is combined with second-reference values that toggle bits 5 and 3, and with both noise levels. A wrong bit in the shared term, or a doubled shift in the hi-hat, would show up as a phase mismatch on part of that sweep. Each key bit is written alone, so a swapped drum mapping gives a wrong flag. A key bit that changes without a strobe, or a write made while rhythm mode is off, checks that the register does not follow the bus. The start flag is tested with one source already holding the operator on. A design that starts on every rising source, and not on the merged key, would pulse there.

// File: rtl/rhy_pkg.sv
package rhy_pkg;
  localparam int PHASE_W = 10;
  localparam int NUM_OPS = 5;

  // key-bit / flag positions; decoded by the operator array
  localparam int OP_HH  = 0;
  localparam int OP_TC  = 1;
  localparam int OP_TOM = 2;
  localparam int OP_SD  = 3;
  localparam int OP_BD  = 4;
endpackage

// File: rtl/rhy_key_latch.sv
module rhy_key_latch #(
  parameter int N = rhy_pkg::NUM_OPS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         wr_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] drum_o
);
  logic [N-1:0] drum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     drum_q <= '0;
    else if (!en_i)  drum_q <= '0;
    else if (wr_i)   drum_q <= bits_i;
  end

  assign drum_o = drum_q;

  a_r1_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i) |=> (drum_o == $past(bits_i)));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wr_i) |=> $stable(drum_o));
  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (drum_o == '0));
endmodule

// File: rtl/rhy_key_track.sv
module rhy_key_track #(
  parameter int N = rhy_pkg::NUM_OPS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] norm_i,
  input  logic [N-1:0] drum_i,
  output logic [N-1:0] on_o,
  output logic [N-1:0] start_o
);
  for (genvar g = 0; g < N; g++) begin : g_op
    logic prev_q;
    logic on_w;

    assign on_w = norm_i[g] | drum_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= on_w;
    end

    assign on_o[g]    = on_w;
    assign start_o[g] = on_w & ~prev_q;

    // a start cannot repeat while the key stays on
    a_r5_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o[g] |=> !(start_o[g] && $past(on_o[g])));
    a_r4_drum_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drum_i[g] |-> on_o[g]);
  end
endmodule

// File: rtl/rhy_phase_mix.sv
module rhy_phase_mix #(
  parameter int PW = rhy_pkg::PHASE_W,
  parameter int N  = rhy_pkg::NUM_OPS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] ref_a_i,
  input  logic [PW-1:0] ref_b_i,
  input  logic          noise_i,
  output logic [PW-1:0] hh_o,
  output logic [PW-1:0] sd_o,
  output logic [PW-1:0] tc_o,
  output logic [N-1:0]  mask_o
);
  import rhy_pkg::*;

  localparam logic [N-1:0] OVR_MASK =
    N'((1 << OP_HH) | (1 << OP_TC) | (1 << OP_SD));
  localparam logic [PW-1:0] HH_SEED = PW'(10'h034);
  localparam logic [PW-1:0] MID_BIT = PW'(10'h100);

  logic          common;
  logic [1:0]    hh_sh;
  logic [PW-1:0] hh_raw, sd_raw, tc_raw;

  always_comb begin
    common = ref_a_i[3] | (ref_a_i[7] ^ ref_a_i[2]) | (ref_b_i[5] ^ ref_b_i[3]);
    hh_sh  = {common ^ noise_i, 1'b0};
    hh_raw = (PW'(common) << 9) | (HH_SEED << hh_sh);
    sd_raw = (MID_BIT << ref_a_i[8]) ^ (PW'(noise_i) << 8);
    tc_raw = MID_BIT | (PW'(common) << 9);
  end

  assign hh_o   = en_i ? hh_raw : '0;
  assign sd_o   = en_i ? sd_raw : '0;
  assign tc_o   = en_i ? tc_raw : '0;
  assign mask_o = en_i ? OVR_MASK : '0;

  a_r3_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (hh_o == '0 && sd_o == '0 && tc_o == '0 && mask_o == '0));
  a_r8_tc_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (tc_o[8] && (tc_o[9] == hh_o[9])));
  a_r7_sd_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> ($countones(sd_o) <= 2 && sd_o[7:0] == '0));
endmodule

// File: rtl/rhy_perc_phase.sv
module rhy_perc_phase
  import rhy_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int N  = NUM_OPS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rhy_en_i,
  input  logic          key_wr_i,
  input  logic [N-1:0]  key_bits_i,
  input  logic [N-1:0]  norm_key_i,
  input  logic [PW-1:0] ref_a_phase_i,
  input  logic [PW-1:0] ref_b_phase_i,
  input  logic          noise_i,
  output logic [N-1:0]  drum_key_o,
  output logic [N-1:0]  op_on_o,
  output logic [N-1:0]  op_start_o,
  output logic [N-1:0]  ovr_mask_o,
  output logic [PW-1:0] hh_phase_o,
  output logic [PW-1:0] sd_phase_o,
  output logic [PW-1:0] tc_phase_o
);
  logic [N-1:0] drum_w;

  rhy_key_latch #(.N(N)) i_latch (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (rhy_en_i),
    .wr_i (key_wr_i), .bits_i (key_bits_i), .drum_o (drum_w)
  );

  rhy_key_track #(.N(N)) i_track (
    .clk_i (clk_i), .rst_ni (rst_ni), .norm_i (norm_key_i),
    .drum_i (drum_w), .on_o (op_on_o), .start_o (op_start_o)
  );

  rhy_phase_mix #(.PW(PW), .N(N)) i_mix (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (rhy_en_i),
    .ref_a_i (ref_a_phase_i), .ref_b_i (ref_b_phase_i), .noise_i (noise_i),
    .hh_o (hh_phase_o), .sd_o (sd_phase_o), .tc_o (tc_phase_o),
    .mask_o (ovr_mask_o)
  );

  assign drum_key_o = drum_w;

  // R9: tom and bass drum keep their own phase
  a_r9_no_tom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rhy_en_i |-> (!ovr_mask_o[OP_TOM] && !ovr_mask_o[OP_BD] && ovr_mask_o[OP_HH]));
endmodule

// File: tb/test_rhy_perc_phase.sv
module test_rhy_perc_phase;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rhy_en = 1'b0, key_wr = 1'b0, noise = 1'b0;
  logic [4:0] key_bits = '0, norm_key = '0;
  logic [9:0] ref_a = '0, ref_b = '0;
  logic [4:0] drum_key, op_on, op_start, ovr_mask;
  logic [9:0] hh_ph, sd_ph, tc_ph;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rhy_perc_phase i_rhy_perc_phase (
    .clk_i (clk), .rst_ni (rst_n), .rhy_en_i (rhy_en), .key_wr_i (key_wr),
    .key_bits_i (key_bits), .norm_key_i (norm_key),
    .ref_a_phase_i (ref_a), .ref_b_phase_i (ref_b), .noise_i (noise),
    .drum_key_o (drum_key), .op_on_o (op_on), .op_start_o (op_start),
    .ovr_mask_o (ovr_mask), .hh_phase_o (hh_ph), .sd_phase_o (sd_ph),
    .tc_phase_o (tc_ph)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic write_keys(input logic [4:0] k);
    @(negedge clk); key_bits = k; key_wr = 1'b1;
    tick();
    @(negedge clk); key_wr = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R10 drum after reset", drum_key, 5'h00);
    check("R3 mask while off", ovr_mask, 5'h00);
    @(negedge clk); rst_n = 1'b1; norm_key = 5'h04;
    #1 check("R10 start at first key", op_start, 5'h04);
    tick();
    check("R10 start clears", op_start, 5'h00);
    @(negedge clk); norm_key = '0;
    tick();
  endtask

  task automatic t_key_map;
    @(negedge clk); rhy_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      write_keys(5'(1 << i));
      check("R1 single key bit", drum_key, 32'(1 << i));
      check("R4 on follows drum", op_on, 32'(1 << i));
    end
    check("R9 override mask", ovr_mask, 5'b01011);
  endtask

  task automatic t_hold;
    write_keys(5'h15);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); key_bits = 5'(i + 8);
      tick();
      check("R2 hold without strobe", drum_key, 5'h15);
    end
  endtask

  task automatic t_disable;
    @(negedge clk); rhy_en = 1'b0; ref_a = 10'h3ff; noise = 1'b1;
    #1;
    check("R3 hh zero", hh_ph, 0);
    check("R3 sd zero", sd_ph, 0);
    check("R3 tc zero", tc_ph, 0);
    check("R3 mask zero", ovr_mask, 0);
    tick();
    check("R3 drum cleared", drum_key, 0);
    write_keys(5'h1f);
    check("R3 write ignored while off", drum_key, 0);
    @(negedge clk); rhy_en = 1'b1;
  endtask

  task automatic t_or;
    write_keys(5'h03);
    @(negedge clk); norm_key = 5'h18;
    #1 check("R4 or of sources", op_on, 5'h1b);
    write_keys(5'h00);
    check("R4 drum write keeps normal", op_on, 5'h18);
    @(negedge clk); norm_key = '0;
    tick();
  endtask

  task automatic t_start;
    @(negedge clk); norm_key = 5'h08;
    #1 check("R5 start on normal key", op_start, 5'h08);
    tick();
    check("R5 start one cycle", op_start, 5'h00);
    write_keys(5'h0a);
    check("R5 start via drum only new op", op_start, 5'h02);
    tick();
    check("R5 no repeat start", op_start, 5'h00);
    @(negedge clk); norm_key = '0;
    write_keys(5'h00);
    tick();
  endtask

  task automatic t_phase;
    logic [9:0] bvals [4];
    bvals[0] = 10'h000; bvals[1] = 10'h008; bvals[2] = 10'h020; bvals[3] = 10'h028;
    @(negedge clk); rhy_en = 1'b1;
    for (int a = 0; a < 1024; a++)
      for (int b = 0; b < 4; b++)
        for (int n = 0; n < 2; n++) begin
          logic c;
          logic [9:0] a_v, b_v, e_hh, e_sd, e_tc;
          a_v = 10'(a); b_v = bvals[b];
          ref_a = a_v; ref_b = b_v; noise = n[0];
          c = a_v[3] | (a_v[7] ^ a_v[2]) | (b_v[5] ^ b_v[3]);
          e_hh = c ? ((n[0] ? 10'h034 : 10'h0d0) | 10'h200) : (n[0] ? 10'h0d0 : 10'h034);
          e_sd = a_v[8] ? (n[0] ? 10'h300 : 10'h200) : (n[0] ? 10'h000 : 10'h100);
          e_tc = c ? 10'h300 : 10'h100;
          #1;
          check("R6 hi-hat phase", hh_ph, e_hh);
          check("R7 snare phase", sd_ph, e_sd);
          check("R8 cymbal phase", tc_ph, e_tc);
        end
  endtask

  initial begin
    t_reset();
    t_key_map();
    t_hold();
    t_disable();
    t_or();
    t_start();
    t_phase();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule